// File: doc/BRIEF.md
# ADC Input Multiplexer Sequencer

This block steps one shared delta-sigma converter through seven analog input slots. Every slot opens on a slow-clock rising edge, which reaches the block as a single-clock strobe that is already synchronised. When a slot opens, the block pulses a start request to the decimation filter. It then waits for the filter's done indication and writes the filter result into a small result RAM at an address fixed for that slot. The result is shifted up by eight bit positions before the write. The block moves on to the next slot only at the slow-clock edge that follows done.

The block also drives the polarity of the reference chopper. The polarity can be held normal, held inverted, or flipped once per full pass through the slots. It changes only at the boundary between two passes. A 2-bit length code sets how many slow-clock periods each conversion is allowed to take. If the filter is late, the block raises a one-clock overrun pulse and keeps waiting.

Top module: `adc_mux_seq`

## Requirements
- R1: A synchronous active-high reset clears fir_start, ram_we, cycle_done, overrun and chop_inv and returns the sequencer to the first slot. No start pulse appears until the first slow_tick after reset is released. That tick starts the current-A slot, and its result goes to address 0x0.
- R2: fir_start is high for exactly one clock, in the clock that follows a slow_tick which opens a slot. It is never high at any other time.
- R3: After fir_done, the next slot is not started until the next slow_tick. A slow_tick sampled in the same clock as fir_done does not start the next slot.
- R4: One clock after a fir_done sampled during a conversion, ram_we is high for one clock. ram_addr is set by the slot, and the slots run in this order: current A 0x0, voltage A 0x3, current B 0x2, voltage B 0x1, temperature 0xA, battery 0xB, auxiliary 0x9. The order then repeats.
- R5: ram_wdata equals the 24-bit fir_result shifted left by 8 within a 32-bit word. The low 8 bits are zero, and any bits above bit 31 are dropped.
- R6: fir_len codes 0, 1 and 2 allow 1, 2 and 3 slow-clock periods per conversion. Code 3 behaves like code 2. The code is taken when the slot starts. If the slow_tick that ends the allowed window arrives without fir_done, overrun pulses for one clock. A later fir_done still writes the result, and the next slow_tick resumes the sequence.
- R7: cycle_done pulses for one clock in the same clock as the fir_start that reopens the current-A slot after the auxiliary slot.
- R8: chop_mode 0 selects normal polarity (chop_inv=0), 1 selects inverted (chop_inv=1), and 2 or 3 selects toggling. chop_inv changes only in a clock where cycle_done is high. At that point it takes the selected polarity, or flips if toggling is selected.
- R9: A fir_done that arrives while no conversion is running produces no RAM write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| slow_tick | input | 1 | One-clock strobe marking a slow-clock rising edge |
| fir_len | input | 2 | Conversion length code |
| chop_mode | input | 2 | Chopper polarity mode |
| fir_done | input | 1 | Filter conversion complete |
| fir_result | input | 24 | Filter output word |
| fir_start | output | 1 | One-clock start request to the filter |
| ram_we | output | 1 | Result RAM write enable |
| ram_addr | output | 4 | Result RAM address |
| ram_wdata | output | 32 | Result RAM write data |
| chop_inv | output | 1 | Chopper polarity, 1 = inverted |
| cycle_done | output | 1 | One-clock pulse at the end of a full slot pass |
| overrun | output | 1 | One-clock pulse when the filter misses its window |

## Verification
The embedded properties check several rules on every clock:
- start requests are single pulses that follow a tick;
- writes follow done and carry the shifted result;
- an overrun coincides with a tick;
- the chopper polarity moves only together with the cycle-done pulse.

Other behaviour is shown only by the bench scenarios, which compare against an independent slot model. These scenarios cover:
- the slot order and addresses;
- the reset restart;
- how the length code sets the overrun deadline;
- the three polarity modes across several passes;
- done arriving on a tick or while idle.

// File: rtl/adc_mux_seq.sv
module adc_mux_seq #(
  parameter int RES_W  = 24,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4,
  parameter int SHIFT  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              slow_tick,
  input  logic [1:0]        fir_len,
  input  logic [1:0]        chop_mode,
  input  logic              fir_done,
  input  logic [RES_W-1:0]  fir_result,
  output logic              fir_start,
  output logic              ram_we,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [DATA_W-1:0] ram_wdata,
  output logic              chop_inv,
  output logic              cycle_done,
  output logic              overrun
);

  localparam int NSLOT  = 7;
  localparam int SLOT_W = $clog2(NSLOT);
  localparam int CAT_W  = RES_W + SHIFT;

  typedef enum logic [1:0] {S_IDLE, S_CONV, S_HOLD} st_t;

  st_t               st;
  logic [SLOT_W-1:0] slot;
  logic [1:0]        ticks, len_q;

  function automatic logic [ADDR_W-1:0] addr_of(input logic [SLOT_W-1:0] s);
    case (s)
      0:       addr_of = ADDR_W'(4'h0);
      1:       addr_of = ADDR_W'(4'h3);
      2:       addr_of = ADDR_W'(4'h2);
      3:       addr_of = ADDR_W'(4'h1);
      4:       addr_of = ADDR_W'(4'hA);
      5:       addr_of = ADDR_W'(4'hB);
      default: addr_of = ADDR_W'(4'h9);
    endcase
  endfunction

  wire             last     = (slot == SLOT_W'(NSLOT-1));
  wire [1:0]       len_req  = (fir_len == 2'd3) ? 2'd3 : fir_len + 2'd1;
  wire             launch   = slow_tick && (st != S_CONV);
  wire             wrap     = launch && (st == S_HOLD) && last;
  wire             finish   = (st == S_CONV) && fir_done;
  wire             counting = (st == S_CONV) && slow_tick && !fir_done && (ticks != len_q);
  wire             expire   = counting && (ticks + 2'd1 == len_q);
  wire             next_pol = (chop_mode == 2'd0) ? 1'b0 :
                              (chop_mode == 2'd1) ? 1'b1 : ~chop_inv;
  wire [CAT_W-1:0] shifted  = {fir_result, {SHIFT{1'b0}}};

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= S_IDLE;
      slot       <= '0;
      ticks      <= '0;
      len_q      <= 2'd1;
      fir_start  <= 1'b0;
      ram_we     <= 1'b0;
      ram_addr   <= '0;
      ram_wdata  <= '0;
      chop_inv   <= 1'b0;
      cycle_done <= 1'b0;
      overrun    <= 1'b0;
    end else begin
      fir_start  <= launch;
      cycle_done <= wrap;
      overrun    <= expire;
      ram_we     <= finish;
      if (finish) begin
        ram_addr  <= addr_of(slot);
        ram_wdata <= DATA_W'(shifted);
        st        <= S_HOLD;
      end else if (counting) begin
        ticks <= ticks + 2'd1;
      end
      if (launch) begin
        st    <= S_CONV;
        ticks <= '0;
        len_q <= len_req;
        if (st == S_HOLD) slot <= last ? '0 : slot + SLOT_W'(1);
      end
      if (wrap) chop_inv <= next_pol;
    end
  end

  p_start_tick_r2: assert property (@(posedge clk) disable iff (rst)
    fir_start |-> $past(slow_tick));
  p_start_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    fir_start |=> !fir_start);
  p_no_start_on_write_r3: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> !fir_start);
  p_write_after_done_r4: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> $past(fir_done));
  p_write_data_r5: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> (ram_wdata == DATA_W'({$past(fir_result), {SHIFT{1'b0}}})));
  p_overrun_tick_r6: assert property (@(posedge clk) disable iff (rst)
    overrun |-> ($past(slow_tick) && !fir_start && !ram_we));
  p_wrap_start_r7: assert property (@(posedge clk) disable iff (rst)
    cycle_done |-> fir_start);
  p_chop_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !cycle_done |-> $stable(chop_inv));

endmodule

// File: tb/adc_mux_seq_tb_top.sv
module adc_mux_seq_tb_top;
  logic        clk = 0, rst = 1, slow_tick = 0, fir_done = 0;
  logic [1:0]  fir_len = 0, chop_mode = 0;
  logic [23:0] fir_result = 0;
  logic        fir_start, ram_we, chop_inv, cycle_done, overrun;
  logic [3:0]  ram_addr;
  logic [31:0] ram_wdata;

  adc_mux_seq dut_i (.clk, .rst, .slow_tick, .fir_len, .chop_mode, .fir_done, .fir_result,
    .fir_start, .ram_we, .ram_addr, .ram_wdata, .chop_inv, .cycle_done, .overrun);

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [35:0] sb_q[$];

  bit m_idle, m_conv, m_chop;
  int m_slot, m_len, m_ticks;

  function automatic logic [3:0] exp_addr(input int s);
    case (s)
      0: exp_addr = 4'h0;  1: exp_addr = 4'h3;  2: exp_addr = 4'h2;
      3: exp_addr = 4'h1;  4: exp_addr = 4'hA;  5: exp_addr = 4'hB;
      default: exp_addr = 4'h9;
    endcase
  endfunction

  task automatic check(input string req, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input bit t, input bit d, input logic [23:0] r);
    @(negedge clk);
    slow_tick = t; fir_done = d; fir_result = r;
  endtask

  task automatic edge_wait();
    @(posedge clk); #1;
  endtask

  always @(negedge clk) begin
    if (!rst && ram_we) begin
      checks++;
      if (sb_q.size() == 0) begin
        errors++;
        $display("FAIL R9 unexpected write actual=%h expected=none", {ram_addr, ram_wdata});
      end else begin
        logic [35:0] e;
        e = sb_q.pop_front();
        if ({ram_addr, ram_wdata} !== e) begin
          errors++;
          $display("FAIL R4/R5 write actual=%h expected=%h", {ram_addr, ram_wdata}, e);
        end
      end
    end
  end

  task automatic do_reset();
    drive(0, 0, 0);
    rst = 1;
    repeat (3) edge_wait();
    check("R1 reset outputs", {31'd0, fir_start, ram_we, cycle_done, overrun, chop_inv}, 36'd0);
    @(negedge clk); rst = 0;
    m_idle = 1; m_conv = 0; m_chop = 0; m_slot = 0; m_ticks = 0; m_len = 1;
  endtask

  task automatic tick();
    bit exp_start, exp_wrap, exp_ov;
    drive(1, 0, 0);
    edge_wait();
    exp_wrap = 0; exp_ov = 0;
    if (!m_conv) begin
      exp_start = 1;
      if (!m_idle) begin
        exp_wrap = (m_slot == 6);
        m_slot = (m_slot + 1) % 7;
      end
      if (exp_wrap) m_chop = (chop_mode == 0) ? 1'b0 : (chop_mode == 1) ? 1'b1 : ~m_chop;
      m_idle = 0; m_conv = 1; m_ticks = 0;
      m_len = (fir_len == 3) ? 3 : fir_len + 1;
    end else begin
      exp_start = 0;
      if (m_ticks < m_len) begin
        m_ticks++;
        exp_ov = (m_ticks == m_len);
      end
    end
    check("R2 start after tick", fir_start, exp_start);
    check("R7 cycle_done", cycle_done, exp_wrap);
    check("R6 overrun", overrun, exp_ov);
    check("R8 chopper", chop_inv, m_chop);
  endtask

  task automatic done(input logic [23:0] r, input bit with_tick);
    drive(with_tick, 1, r);
    if (m_conv) sb_q.push_back({exp_addr(m_slot), r, 8'h00});
    m_conv = 0;
    edge_wait();
    check("R3 no start on done", fir_start, 1'b0);
    check("R6 no overrun on done", overrun, 1'b0);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      drive(0, 0, 0);
      edge_wait();
      check("R3 no start without tick", fir_start, 1'b0);
      check("R8 chopper stable", chop_inv, m_chop);
    end
  endtask

  task automatic run_slot(input logic [23:0] r);
    idle(1);
    done(r, 0);
    idle(2);
    tick();
  endtask

  initial begin
    do_reset();
    idle(3);
    done(24'h111111, 0);
    idle(2);
    tick();
    chop_mode = 2;
    for (int c = 0; c < 3; c++)
      for (int s = 0; s < 7; s++) run_slot(24'h010203 + 24'(c * 16 + s));
    done(24'hFFFFFF, 1);
    idle(1);
    tick();
    fir_len = 1;
    done(24'hABCDEF, 0);
    tick();
    tick();
    tick();
    idle(1);
    done(24'h5A5A5A, 0);
    tick();
    fir_len = 2;
    tick();
    tick();
    done(24'h00C0DE, 0);
    tick();
    fir_len = 3;
    tick(); tick(); tick();
    done(24'h123456, 0);
    tick();
    fir_len = 0;
    chop_mode = 1;
    for (int s = 0; s < 8; s++) run_slot(24'h800000 + 24'(s));
    chop_mode = 0;
    for (int s = 0; s < 8; s++) run_slot(24'h400000 + 24'(s));
    chop_mode = 3;
    for (int s = 0; s < 7; s++) run_slot(24'h200000 + 24'(s));
    done(24'h777777, 0);
    idle(2);
    do_reset();
    idle(2);
    tick();
    done(24'h0BEEF0, 0);
    idle(3);
    check("R4 scoreboard drained", 36'(sb_q.size()), 36'd0);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule